// File: doc/BRIEF.md
# Multi-CPU Host Bus Slave Adapter

This block is a synchronous 32-bit slave on a host processor bus, clocked by the bus clock. One port serves four processor bus flavours. Two strap inputs pick the flavour and a third picks where the ready line rests between cycles. The straps are sampled once, on the first clock edge after reset is released. After that edge, the polarity of the ready/wait line, the interrupt line and the DMA handshake are fixed until the next reset.

An access starts when chip select and bus start are both low at a clock edge and either the read strobe or one of the four byte write strobes is low. The adapter latches the address, the direction, the byte lanes and the write data, then raises a request to a simple back end. It holds the wait level on the ready line until the back end returns done. On the next clock it shows the ready level for exactly one cycle, and in that cycle it drives read data. For flavour C the top address bit gives the direction instead of acting as an address bit. One word address, with all low address bits set, is answered inside the adapter: a read there returns the latched flavour code.

Top module: `host_bus_slave`

## Requirements
- R1: The flavour code (strap_cpu: 00 = A, 01 = B, 10 = C, 11 = D) and the park strap are sampled on the first rising clock edge after rst_n goes high. Strap changes after that edge have no effect until the next reset.
- R2: rdy_oe is high exactly while cs_n is low.
- R3: The wait level on rdy_o is 0 for flavour A and 1 for flavours B, C and D. The ready level is the inverse of the wait level.
- R4: A cycle starts at a clock edge where cs_n and bs_n are low and either rd_n or any we_n bit is low. be_req stays high, with a stable be_addr, until be_done is sampled. The ready level is then shown for one cycle, and the slave returns to idle. The number of wait cycles equals the back end latency in cycles.
- R5: While idle, rdy_o rests at the ready level when strap_park was 1 and at the wait level when it was 0. Every cycle therefore lasts at least two clocks.
- R6: data_oe is high only in the ready cycle of a read while cs_n is low. In that cycle data_o carries the word captured from be_rdata, or the internal register value.
- R7: we_n[0] enables byte 7:0, we_n[1] byte 15:8, we_n[2] byte 23:16 and we_n[3] byte 31:24. be_ben is the inverse of we_n, and be_wdata is data_i, both captured at the start edge.
- R8: For flavour C, addr[22] = 1 means write and 0 means read, and be_addr[22] is 0. For the other flavours be_we follows the write strobes and be_addr equals addr.
- R9: irq_out follows irq_src one clock later. It is active low for flavours A and B and active high for C and D.
- R10: dreq_out is an active-low copy of dma_src, one clock later. dma_beat pulses one clock after dack_in is high while dtack_in is active. dtack_in is active high except for flavour C, where it is active low.
- R11: An access whose addr[21:0] are all ones reaches the internal register and never raises be_req. A read there returns the flavour code in bits 1:0 after one wait cycle. A write there is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_cpu | input | 2 | Bus flavour select strap |
| strap_park | input | 1 | Idle ready-level strap |
| cs_n | input | 1 | Chip select, active low |
| bs_n | input | 1 | Bus cycle start, active low |
| rd_n | input | 1 | Read strobe, active low |
| we_n | input | 4 | Byte write strobes, active low |
| addr | input | 23 | Word address |
| data_i | input | 32 | Write data from the bus |
| data_o | output | 32 | Read data to the bus |
| data_oe | output | 1 | Data bus drive enable |
| rdy_o | output | 1 | Ready/wait line value |
| rdy_oe | output | 1 | Ready/wait line drive enable |
| irq_src | input | 1 | Internal interrupt request, active high |
| irq_out | output | 1 | Interrupt to the host |
| dma_src | input | 1 | Internal DMA need, active high |
| dreq_out | output | 1 | DMA request, active low |
| dack_in | input | 1 | DMA acknowledge, active high |
| dtack_in | input | 1 | DMA transfer strobe |
| dma_beat | output | 1 | One pulse per acknowledged transfer strobe |
| be_req | output | 1 | Back end request |
| be_we | output | 1 | Back end write direction |
| be_addr | output | 23 | Back end word address |
| be_wdata | output | 32 | Back end write data |
| be_ben | output | 4 | Back end byte enables |
| be_rdata | input | 32 | Back end read data |
| be_done | input | 1 | Back end completion |

## Verification
Latching the wrong strap value shows up within a single access: the wait and ready levels on rdy_o come out inverted, or the register read returns the wrong code. A state machine stuck in the wait state never shows the ready level. A state machine that leaves the ready state late shows a second ready cycle where the idle level belongs. Both are visible on the very next clock. Wrongly captured cycle fields show on be_addr, be_ben and be_wdata in the first wait cycle. Errors in the read path show on data_o in the one ready cycle.

// File: rtl/host_bus_slave.sv
module host_bus_slave #(
  parameter int AW = 23,
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    strap_cpu,
  input  logic          strap_park,
  input  logic          cs_n,
  input  logic          bs_n,
  input  logic          rd_n,
  input  logic [NB-1:0] we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          rdy_o,
  output logic          rdy_oe,
  input  logic          irq_src,
  output logic          irq_out,
  input  logic          dma_src,
  output logic          dreq_out,
  input  logic          dack_in,
  input  logic          dtack_in,
  output logic          dma_beat,
  output logic          be_req,
  output logic          be_we,
  output logic [AW-1:0] be_addr,
  output logic [DW-1:0] be_wdata,
  output logic [NB-1:0] be_ben,
  input  logic [DW-1:0] be_rdata,
  input  logic          be_done
);

  localparam logic [1:0] CPU_A = 2'b00;
  localparam logic [1:0] CPU_C = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_ACK} st_t;

  st_t           st;
  logic          armed, park;
  logic [1:0]    cpu;
  logic          c_we, c_reg;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata, rdata_q;
  logic [NB-1:0] c_ben;
  logic          irq_q, dreq_q;

  wire is_c     = (cpu == CPU_C);
  wire wait_lvl = (cpu != CPU_A);
  wire rd_act   = !rd_n;
  wire wr_act   = |(~we_n);
  wire start    = !armed && (st == S_IDLE) && !cs_n && !bs_n && (rd_act || wr_act);
  wire dir_wr   = is_c ? addr[AW-1] : wr_act;
  wire reg_hit  = &addr[AW-2:0];
  wire done_eff = c_reg || be_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      cpu   <= CPU_A;
      park  <= 1'b0;
    end else if (armed) begin
      armed <= 1'b0;
      cpu   <= strap_cpu;
      park  <= strap_park;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      c_we    <= 1'b0;
      c_reg   <= 1'b0;
      c_addr  <= '0;
      c_wdata <= '0;
      c_ben   <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_BUSY;
          c_we    <= dir_wr;
          c_reg   <= reg_hit;
          c_addr  <= is_c ? {1'b0, addr[AW-2:0]} : addr;
          c_wdata <= data_i;
          c_ben   <= ~we_n;
        end
        S_BUSY: if (done_eff) begin
          st      <= S_ACK;
          rdata_q <= c_reg ? {{(DW-2){1'b0}}, cpu} : be_rdata;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      dreq_q   <= 1'b0;
      dma_beat <= 1'b0;
    end else begin
      irq_q    <= irq_src;
      dreq_q   <= dma_src;
      dma_beat <= dack_in && (dtack_in ^ is_c);
    end
  end

  assign irq_out  = cpu[1] ? irq_q : !irq_q;
  assign dreq_out = !dreq_q;

  assign be_req   = (st == S_BUSY) && !c_reg;
  assign be_we    = c_we;
  assign be_addr  = c_addr;
  assign be_wdata = c_wdata;
  assign be_ben   = c_ben;

  assign rdy_oe  = !cs_n;
  assign rdy_o   = (st == S_BUSY) ? wait_lvl :
                   (st == S_ACK)  ? !wait_lvl :
                   (park ? !wait_lvl : wait_lvl);
  assign data_oe = (st == S_ACK) && !c_we && !cs_n;
  assign data_o  = data_oe ? rdata_q : '0;

  a_r4_done_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && be_done) |=> (st == S_ACK));

  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK) |=> (st == S_IDLE));

  a_r1_straps_held: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> ($stable(cpu) && $stable(park)));

  a_r4_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_done) |=> (be_req && $stable(be_addr)));

  a_r6_data_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(st == S_BUSY));

endmodule

// File: tb/host_bus_slave_bench.sv
module host_bus_slave_bench;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  strap_cpu = 0;
  logic        strap_park = 0;
  logic        cs_n = 1, bs_n = 1, rd_n = 1;
  logic [3:0]  we_n = 4'hF;
  logic [22:0] addr = 0;
  logic [31:0] data_i = 0, data_o, be_wdata, be_rdata;
  logic        data_oe, rdy_o, rdy_oe, irq_out, dreq_out, dma_beat;
  logic        irq_src = 0, dma_src = 0, dack_in = 0, dtack_in = 0;
  logic        be_req, be_we, be_done = 0;
  logic [22:0] be_addr;
  logic [3:0]  be_ben;

  int n_run = 0, n_fail = 0;
  logic [1:0] cur_cpu;
  logic       cur_park;

  always #10 clk = ~clk;

  assign be_rdata = {9'h0, be_addr} ^ 32'h5A00_0000;

  host_bus_slave u_host_bus_slave (
    .clk, .rst_n, .strap_cpu, .strap_park, .cs_n, .bs_n, .rd_n, .we_n, .addr,
    .data_i, .data_o, .data_oe, .rdy_o, .rdy_oe, .irq_src, .irq_out,
    .dma_src, .dreq_out, .dack_in, .dtack_in, .dma_beat, .be_req, .be_we,
    .be_addr, .be_wdata, .be_ben, .be_rdata, .be_done
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic wait_exp();
    return cur_cpu != 2'b00;
  endfunction

  function automatic logic park_exp();
    return cur_park ? !wait_exp() : wait_exp();
  endfunction

  task automatic do_reset(input logic [1:0] c, input logic p);
    @(negedge clk);
    rst_n = 0; strap_cpu = c; strap_park = p; cur_cpu = c; cur_park = p;
    repeat (3) @(negedge clk);
    chk(be_req == 0 && data_oe == 0 && rdy_oe == 0, "R2 reset", {29'h0, be_req, data_oe, rdy_oe}, 0);
    chk(dreq_out == 1, "R10 reset", {31'h0, dreq_out}, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic access(input bit wr, input logic [22:0] a, input logic [31:0] wd,
                        input logic [3:0] ben, input int lat);
    bit is_c = (cur_cpu == 2'b10);
    bit reg_exp = &a[21:0];
    logic [22:0] ea = is_c ? {1'b0, a[21:0]} : a;
    int waits = 0, k = 0;
    bit seen_req = 0, got = 0;
    cs_n = 0; bs_n = 0;
    addr = is_c ? {wr, a[21:0]} : a;
    rd_n = wr;
    we_n = wr ? ~ben : 4'hF;
    data_i = wd;
    #1;
    chk(rdy_oe == 1, "R2 drive", {31'h0, rdy_oe}, 1);
    chk(rdy_o == park_exp(), "R5 park", {31'h0, rdy_o}, {31'h0, park_exp()});
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      bs_n = 1;
      if (rdy_o == !wait_exp()) begin got = 1; break; end
      waits++;
      if (be_req) begin
        if (!seen_req) begin
          chk(be_addr == ea, "R8 addr", {9'h0, be_addr}, {9'h0, ea});
          chk(be_we == wr, "R8 dir", {31'h0, be_we}, {31'h0, wr});
          if (wr) begin
            chk(be_ben == ben, "R7 lanes", {28'h0, be_ben}, {28'h0, ben});
            chk(be_wdata == wd, "R7 wdata", be_wdata, wd);
          end
        end
        seen_req = 1;
        k++;
        if (k == lat) be_done = 1;
      end
    end
    be_done = 0;
    chk(got, "R3 ready level seen", {31'h0, got}, 1);
    chk(waits == (reg_exp ? 1 : lat), reg_exp ? "R11 waits" : "R4 waits", waits, reg_exp ? 1 : lat);
    chk(seen_req == !reg_exp, "R11 request", {31'h0, seen_req}, {31'h0, !reg_exp});
    chk(data_oe == !wr, "R6 oe", {31'h0, data_oe}, {31'h0, !wr});
    if (!wr)
      chk(data_o == (reg_exp ? {30'h0, cur_cpu} : ({9'h0, ea} ^ 32'h5A00_0000)),
          "R6 data", data_o, reg_exp ? {30'h0, cur_cpu} : ({9'h0, ea} ^ 32'h5A00_0000));
    @(negedge clk);
    chk(rdy_o == park_exp() && data_oe == 0, "R4 single ack", {30'h0, rdy_o, data_oe}, {30'h0, park_exp(), 1'b0});
    cs_n = 1; rd_n = 1; we_n = 4'hF;
    #1;
    chk(rdy_oe == 0 && data_oe == 0, "R2 release", {30'h0, rdy_oe, data_oe}, 0);
    @(negedge clk);
  endtask

  task automatic side_lines();
    logic act = cur_cpu[1];
    @(negedge clk); irq_src = 1;
    @(negedge clk); chk(irq_out == act, "R9 irq on", {31'h0, irq_out}, {31'h0, act});
    irq_src = 0;
    @(negedge clk); chk(irq_out == !act, "R9 irq off", {31'h0, irq_out}, {31'h0, !act});
    dma_src = 1;
    @(negedge clk); chk(dreq_out == 0, "R10 dreq on", {31'h0, dreq_out}, 0);
    dma_src = 0; dack_in = 1; dtack_in = (cur_cpu != 2'b10);
    @(negedge clk); chk(dreq_out == 1 && dma_beat == 1, "R10 beat", {30'h0, dreq_out, dma_beat}, 3);
    dtack_in = !dtack_in;
    @(negedge clk); chk(dma_beat == 0, "R10 strobe idle", {31'h0, dma_beat}, 0);
    dack_in = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[1:0], cfg[2]);
      side_lines();
      for (int lat = 1; lat <= 3; lat++) begin
        access(1'b0, 23'h000120 + lat, 0, 4'h0, lat);
        access(1'b1, 23'h000200 + lat, 32'hC0DE_0000 + lat, 4'h1 << (lat - 1), lat);
      end
      access(1'b1, 23'h400055, 32'h1234_5678, 4'hF, 2);
      access(1'b0, 23'h400066, 0, 4'h0, 1);
      access(1'b0, 23'h3FFFFF, 0, 4'h0, 1);
      access(1'b1, 23'h3FFFFF, 32'hFFFF_FFFF, 4'hF, 1);
      access(1'b0, 23'h3FFFFF, 0, 4'h0, 1);
      strap_cpu = ~cur_cpu; strap_park = !cur_park;
      access(1'b0, 23'h3FFFFF, 0, 4'h0, 1);
      access(1'b0, 23'h000010, 0, 4'h0, 4);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule